// File: doc/BRIEF.md
# Multi-Channel LED Dimming Output Stage

This block turns per-channel brightness settings into drive levels for a row of LED outputs. Every channel compares its own 8-bit duty value against a shared fast counter to make a 256-step brightness waveform. A single shared group waveform can be gated onto selected channels. It runs either as a slow global dimmer stepped by an external tick, or as a blinker whose period comes from a register. A 2-bit state code per channel picks one of four behaviours: forced off, forced on, individual PWM only, or individual PWM gated by the group waveform.

The surrounding logic supplies the register values and three timebase strobes. The strobes are the fast PWM step, the dim-mode group step and the blink base tick. It also supplies an active-low enable pin. When the enable is high, every channel goes to one selectable disabled condition. While enabled, an invert control flips the polarity of every level. New duty values are captured only when their counter wraps, so a PWM cycle is never cut short or stretched by a write. Outputs are registered once.

Top module: `led_pwm_stage`

## Requirements
- R1: A shared 8-bit fast counter advances by one on each `fast_tick`. A channel's individual waveform is high while that count is below the channel's captured duty. A duty of 255 is therefore high for 255 of 256 steps and never continuously.
- R2: The state code for channel i is `chan_state[2i+1:2i]`. Code 00 drives the raw level low. Code 01 drives it high. Code 10 gives the individual waveform. Code 11 gives the individual waveform ANDed with the group waveform.
- R3: With `blink_mode`=0, the 8-bit group counter advances by one on each `grp_tick`. The group waveform is high while the group count is below the captured group duty.
- R4: With `blink_mode`=1, `grp_tick` is ignored and the group counter advances once every `blink_period`+1 pulses of `blink_tick`. One blink therefore lasts 256×(`blink_period`+1) blink ticks and is lit for `grp_duty`×(`blink_period`+1) of them.
- R5: A channel's duty (`chan_duty[8i+7:8i]`) is captured only on a fast tick that wraps the fast counter from 255 to 0. The group duty is captured only on a group step that wraps the group counter. Between captures, changes to either input have no effect.
- R6: With `oe_n`=0, `invert`=1 inverts every channel's level, and `led_drive_en` is 1.
- R7: With `oe_n`=1, the state codes and `invert` are ignored. `dis_sel`=00 gives level 0 with drive enabled. `dis_sel`=01 gives level 1 with drive enabled. `dis_sel`=10 or 11 gives level 0 with drive released (`led_drive_en`=0).
- R8: A synchronous low `rst_n` clears both counters, the blink prescaler and all captured duties, and sets every `led_level` to 0 and every `led_drive_en` to 1.
- R9: The outputs are registered. Each rising edge computes them from the inputs present at that edge and from the counter and captured-duty values held just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_tick | input | 1 | Step strobe for the individual PWM counter |
| grp_tick | input | 1 | Group counter step strobe in dim mode |
| blink_tick | input | 1 | Base tick for the blink prescaler |
| blink_mode | input | 1 | 0 = group dims, 1 = group blinks |
| invert | input | 1 | Flip output polarity while enabled |
| oe_n | input | 1 | Active-low output enable |
| dis_sel | input | 2 | Disabled-condition select |
| grp_duty | input | 8 | Group duty value |
| blink_period | input | 8 | Blink prescaler limit |
| chan_duty | input | NCH*8 | Packed per-channel duty values |
| chan_state | input | NCH*2 | Packed per-channel state codes |
| led_level | output | NCH | Per-channel drive level |
| led_drive_en | output | NCH | Per-channel drive-active indication |

## Verification
The embedded assertions watch properties that hold on every cycle:
- counter stepping;
- the captured duties holding between wraps;
- the group counter freezing between blink ticks;
- the fixed levels for codes 00 and 01;
- the released drive in the floating disabled condition;
- the fact that a duty of 255 is low at count 255.

Only the bench's scenarios can show the waveform shapes over whole cycles. Those are the brightness ratios, the group gating in dim and blink mode at a given period, and the deferred take-up of a duty written mid-cycle. They also include the one-edge latency of every output change.

// File: rtl/led_pkg.sv
// Shared encodings for the LED output stage.
package led_pkg;
    // Per-channel behaviour selector.
    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_ON   = 2'b01,
        ST_IND  = 2'b10,
        ST_BOTH = 2'b11
    } chan_state_e;

    // Condition applied to all channels while the enable pin is high.
    typedef enum logic [1:0] {
        DIS_LOW   = 2'b00,
        DIS_HIGH  = 2'b01,
        DIS_FLOAT = 2'b10,
        DIS_FLT2  = 2'b11
    } dis_sel_e;
endpackage

// File: rtl/led_fast_cnt.sv
// Free-running wrap-around step counter.
// Advances by one on each step strobe. Flags the step that wraps
// from all-ones to zero. Assumes the strobe lasts one clock per step.
module led_fast_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Step the counter on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (step)
            count <= count + 1'b1;
    end

    // Flag the step that returns the count to zero.
    always_comb wrap = step && (count == CNT_MAX);

    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/led_grp_pwm.sv
// Shared group waveform generator.
// In dim mode the counter steps on an external strobe. In blink mode it
// steps once per (period+1) blink ticks. The duty is captured at each
// counter wrap. Assumes the strobes last one clock each.
module led_grp_pwm #(
    parameter int CNT_W = 8,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blink_mode,
    input  logic             grp_tick,
    input  logic             blink_tick,
    input  logic [PER_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic             grp_on
);
    logic [PER_W-1:0] pre_cnt;
    logic             g_step;
    logic [CNT_W-1:0] gcnt;
    logic             gwrap;
    logic [CNT_W-1:0] duty_lat;

    // Pick the group step source for the current mode.
    always_comb g_step = blink_mode ? (blink_tick && (pre_cnt >= period)) : grp_tick;

    // Blink prescaler: count blink ticks up to the period limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !blink_mode)
            pre_cnt <= '0;
        else if (blink_tick)
            pre_cnt <= (pre_cnt >= period) ? '0 : pre_cnt + 1'b1;
    end

    led_fast_cnt #(.CNT_W(CNT_W)) u_gcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (g_step),
        .count (gcnt),
        .wrap  (gwrap)
    );

    // Capture the group duty only at a cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            duty_lat <= '0;
        else if (gwrap)
            duty_lat <= duty;
    end

    // Group waveform compare.
    always_comb grp_on = gcnt < duty_lat;

    assert_grp_lat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !gwrap |=> $stable(duty_lat));
    assert_blink_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_mode && !blink_tick) |=> $stable(gcnt));
endmodule

// File: rtl/led_chan.sv
// One output channel.
// Captures its duty at the fast-counter wrap and selects the raw level
// by state code. It then applies enable, disabled condition and polarity,
// and registers the result. Assumes a shared fast count and wrap flag.
module led_chan
    import led_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fcnt,
    input  logic             fwrap,
    input  logic [CNT_W-1:0] duty_in,
    input  chan_state_e      state,
    input  logic             grp_on,
    input  logic             invert,
    input  logic             oe_n,
    input  dis_sel_e         dis_sel,
    output logic             level,
    output logic             drive_en
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] duty_lat;
    logic             ind_on;
    logic             raw;
    logic             lvl_nx;
    logic             en_nx;

    // Capture the channel duty only at a cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            duty_lat <= '0;
        else if (fwrap)
            duty_lat <= duty_in;
    end

    // Individual brightness compare.
    always_comb ind_on = fcnt < duty_lat;

    // Select the raw level by state code.
    always_comb begin
        unique case (state)
            ST_OFF:  raw = 1'b0;
            ST_ON:   raw = 1'b1;
            ST_IND:  raw = ind_on;
            ST_BOTH: raw = ind_on && grp_on;
            default: raw = 1'b0;
        endcase
    end

    // Apply enable, disabled condition and polarity.
    always_comb begin
        if (oe_n) begin
            unique case (dis_sel)
                DIS_LOW:  begin lvl_nx = 1'b0; en_nx = 1'b1; end
                DIS_HIGH: begin lvl_nx = 1'b1; en_nx = 1'b1; end
                default:  begin lvl_nx = 1'b0; en_nx = 1'b0; end
            endcase
        end else begin
            lvl_nx = raw ^ invert;
            en_nx  = 1'b1;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level    <= 1'b0;
            drive_en <= 1'b1;
        end else begin
            level    <= lvl_nx;
            drive_en <= en_nx;
        end
    end

    assert_lat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fwrap |=> $stable(duty_lat));
    assert_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !oe_n) |=> (level == $past(invert)));
    assert_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && !oe_n) |=> (level == !$past(invert)));
    assert_never_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fcnt == CNT_MAX && state == ST_IND && !oe_n && !invert) |=> !level);
    assert_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && dis_sel[1]) |=> (!drive_en && !level));
endmodule

// File: rtl/led_pwm_stage.sv
// Multi-channel LED output stage.
// Uses one shared fast counter, one shared group waveform and NCH
// channels. Register values arrive already stored. The strobes last
// one clock each.
module led_pwm_stage
    import led_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 8,
    parameter int PER_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fast_tick,
    input  logic                 grp_tick,
    input  logic                 blink_tick,
    input  logic                 blink_mode,
    input  logic                 invert,
    input  logic                 oe_n,
    input  logic [1:0]           dis_sel,
    input  logic [CNT_W-1:0]     grp_duty,
    input  logic [PER_W-1:0]     blink_period,
    input  logic [NCH*CNT_W-1:0] chan_duty,
    input  logic [NCH*2-1:0]     chan_state,
    output logic [NCH-1:0]       led_level,
    output logic [NCH-1:0]       led_drive_en
);
    logic [CNT_W-1:0] fcnt;
    logic             fwrap;
    logic             grp_on;

    led_fast_cnt #(.CNT_W(CNT_W)) u_fcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (fast_tick),
        .count (fcnt),
        .wrap  (fwrap)
    );

    led_grp_pwm #(.CNT_W(CNT_W), .PER_W(PER_W)) u_grp (
        .clk        (clk),
        .rst_n      (rst_n),
        .blink_mode (blink_mode),
        .grp_tick   (grp_tick),
        .blink_tick (blink_tick),
        .period     (blink_period),
        .duty       (grp_duty),
        .grp_on     (grp_on)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        led_chan #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .fcnt     (fcnt),
            .fwrap    (fwrap),
            .duty_in  (chan_duty[i*CNT_W +: CNT_W]),
            .state    (chan_state_e'(chan_state[i*2 +: 2])),
            .grp_on   (grp_on),
            .invert   (invert),
            .oe_n     (oe_n),
            .dis_sel  (dis_sel_e'(dis_sel)),
            .level    (led_level[i]),
            .drive_en (led_drive_en[i])
        );
    end
endmodule

// File: tb/led_pwm_stage_test.sv
module led_pwm_stage_test;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fast_tick = 0, grp_tick = 0, blink_tick = 0, blink_mode = 0;
    logic invert = 0, oe_n = 0;
    logic [1:0] dis_sel = 2'b00;
    logic [7:0] grp_duty = 0, blink_period = 0;
    logic [7:0] duty [NCH];
    logic [1:0] st [NCH];
    logic [NCH*8-1:0] chan_duty;
    logic [NCH*2-1:0] chan_state;
    logic [NCH-1:0] led_level, led_drive_en;

    int vectors = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            chan_duty[i*8 +: 8] = duty[i];
            chan_state[i*2 +: 2] = st[i];
        end
    end

    led_pwm_stage #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .grp_tick(grp_tick),
        .blink_tick(blink_tick), .blink_mode(blink_mode), .invert(invert),
        .oe_n(oe_n), .dis_sel(dis_sel), .grp_duty(grp_duty),
        .blink_period(blink_period), .chan_duty(chan_duty),
        .chan_state(chan_state), .led_level(led_level), .led_drive_en(led_drive_en)
    );

    // Reference model state, built from the requirements
    logic [7:0] m_fcnt, m_gcnt, m_pre, m_glat;
    logic [7:0] m_dlat [NCH];

    // Scoreboard queues
    logic [NCH-1:0] q_lvl [$];
    logic [NCH-1:0] q_en [$];
    string q_tag [$];

    task automatic model_reset();
        m_fcnt = 0; m_gcnt = 0; m_pre = 0; m_glat = 0;
        for (int i = 0; i < NCH; i++) m_dlat[i] = 0;
    endtask

    // Driver: apply one cycle of strobes, push the expected outputs, advance model.
    task automatic step(input logic ft, input logic gt, input logic bt, input string tag);
        logic [NCH-1:0] el, ee;
        logic ind, grp, raw, gstep;
        fast_tick = ft; grp_tick = gt; blink_tick = bt;
        grp = m_gcnt < m_glat;
        for (int i = 0; i < NCH; i++) begin
            ind = m_fcnt < m_dlat[i];
            case (st[i])
                2'b00: raw = 0;
                2'b01: raw = 1;
                2'b10: raw = ind;
                default: raw = ind & grp;
            endcase
            if (oe_n) begin
                el[i] = (dis_sel == 2'b01);
                ee[i] = !dis_sel[1];
            end else begin
                el[i] = raw ^ invert;
                ee[i] = 1'b1;
            end
        end
        q_lvl.push_back(el); q_en.push_back(ee); q_tag.push_back(tag);
        // R5: capture only at the wrap
        if (ft && m_fcnt == 8'hFF)
            for (int i = 0; i < NCH; i++) m_dlat[i] = duty[i];
        if (ft) m_fcnt = m_fcnt + 1;
        if (blink_mode) begin
            gstep = bt && (m_pre >= blink_period);
            if (bt) m_pre = (m_pre >= blink_period) ? 8'd0 : m_pre + 1;
        end else begin
            gstep = gt;
            m_pre = 0;
        end
        if (gstep) begin
            if (m_gcnt == 8'hFF) m_glat = grp_duty;
            m_gcnt = m_gcnt + 1;
        end
        @(posedge clk); #3;
        fast_tick = 0; grp_tick = 0; blink_tick = 0;
    endtask

    // Monitor: pop and compare one edge after each push
    initial forever begin
        @(posedge clk); #1;
        if (q_lvl.size() > 0) begin
            logic [NCH-1:0] el, ee;
            string tg;
            el = q_lvl.pop_front(); ee = q_en.pop_front(); tg = q_tag.pop_front();
            vectors++;
            if (led_level !== el || led_drive_en !== ee) begin
                errors++;
                $display("FAIL %s: level=%b en=%b expected level=%b en=%b",
                         tg, led_level, led_drive_en, el, ee);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin duty[i] = 8'd0; st[i] = 2'b00; end
        model_reset();
        // R8: reset state
        invert = 1; oe_n = 1; dis_sel = 2'b01;
        repeat (3) @(posedge clk);
        #1;
        vectors++;
        if (led_level !== '0 || led_drive_en !== '1) begin
            errors++;
            $display("FAIL R8: level=%b en=%b expected level=0000 en=1111", led_level, led_drive_en);
        end
        invert = 0; oe_n = 0; dis_sel = 2'b00;
        @(posedge clk); #2;
        rst_n = 1;
        @(posedge clk); #3;

        // R2 / R6: fixed codes with both polarities
        st[0] = 2'b00; st[1] = 2'b01; st[2] = 2'b00; st[3] = 2'b01;
        step(0, 0, 0, "R2 fixed codes");
        invert = 1;
        step(0, 0, 0, "R6 inverted fixed codes");
        step(1, 0, 0, "R6 inverted fixed codes");
        invert = 0;

        // R1 / R5: individual PWM; duty captured only at the wrap
        duty[0] = 8'd0; duty[1] = 8'd1; duty[2] = 8'd128; duty[3] = 8'd255;
        for (int i = 0; i < NCH; i++) st[i] = 2'b10;
        for (int n = 0; n < 700; n++) begin
            if (n == 400) begin
                duty[0] = 8'd3; duty[1] = 8'd200; duty[2] = 8'd17;
            end
            step(1, 0, 0, (n < 256 || n == 400) ? "R5 deferred duty" : "R1 individual pwm");
        end
        for (int n = 0; n < 40; n++) step(n % 3 == 0, 0, 0, "R1 sparse ticks");

        // R3: dim mode, both waveforms combined
        for (int i = 0; i < NCH; i++) st[i] = 2'b11;
        st[3] = 2'b10;
        grp_duty = 8'd64;
        for (int n = 0; n < 900; n++) step(1, (n % 3) != 0, 1, "R3 group dim");
        grp_duty = 8'd200;
        for (int n = 0; n < 500; n++) step(1, 1, 0, "R3 group dim");

        // R4: blink mode, grp_tick ignored
        blink_mode = 1; blink_period = 8'd2; grp_duty = 8'd100;
        for (int n = 0; n < 1800; n++) step(1, 1, 1, "R4 blink");
        blink_period = 8'd0; grp_duty = 8'd30;
        for (int n = 0; n < 700; n++) step(n % 5 != 0, 1, n % 2 == 0, "R4 blink sparse");
        blink_mode = 0;

        // R7: disabled conditions ignore codes and invert
        invert = 1;
        oe_n = 1;
        dis_sel = 2'b00; step(1, 0, 0, "R7 disabled low");
        dis_sel = 2'b01; step(1, 0, 0, "R7 disabled high");
        dis_sel = 2'b10; step(1, 0, 0, "R7 disabled float");
        dis_sel = 2'b11; step(1, 0, 0, "R7 disabled float");
        // R9: re-enable shows up one edge later
        oe_n = 0;
        step(1, 0, 0, "R9 re-enable latency");
        st[0] = 2'b01; st[1] = 2'b00;
        step(1, 0, 0, "R9 code change latency");
        invert = 0;
        step(0, 0, 0, "R6 polarity restore");

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule